// File: doc/BRIEF.md
# Audio Transmit Sample FIFO

This block is the transmit sample buffer for one audio channel. A processor hands it data words. The block widens each word to a 20-bit sample that is aligned to the top of the field, stores the samples in a circular buffer, and sends them to a codec as left/right stereo pairs.

In normal mode each word gives one sample. In packed mode a 32-bit word carries two 16-bit halves, and the block stores both. Packed mode applies only to the 12-bit and 16-bit sample sizes. The block keeps four status flags up to date: empty, half-empty, full and underrun.

Sending waits until the buffer is at least half full. Once a burst has started, it continues pair by pair until fewer than two samples are left.

The input stream uses `in_valid`/`in_ready`. The write side cannot stall the writer. `in_ready` reports whether a word offered now would fit. A word offered while `in_ready` is low is discarded and changes nothing.

The output stream uses `pair_valid`/`pair_ready`. The codec applies back-pressure by holding `pair_ready` low. While it does, the pair on offer stays stable, provided the configuration is unchanged. One pair is removed on each cycle where `pair_valid` and `pair_ready` are both high.

Top module: `audio_tx_fifo`

## Requirements
- R1: After reset, st_empty=1, st_half_empty=1, st_full=0, st_underrun=0 and pair_valid=0.
- R2: size_code selects the sample width: 0 is 16 bits, 1 is 18 bits, 2 is 20 bits, 3 is 12 bits. In normal mode a word is shifted left by 4, 2, 0 or 8 for codes 0, 1, 2, 3, and bits 19:0 of the result form the sample.
- R3: In packed mode (compact_req=1 with code 0 or 3), a word stores two samples. Bits 15:0 are stored first and bits 31:16 second. Each half is shifted left by 8 for code 3 and by 4 for code 0, then cut to 20 bits.
- R4: With code 1 or 2, compact_req has no effect and each word stores exactly one sample.
- R5: A normal word is accepted only when the fill level is below DEPTH. A packed word is accepted only when the level plus 2 is below DEPTH. in_ready shows this rule, and a refused word is dropped.
- R6: A push clears st_empty and st_underrun. It clears st_half_empty when the new level reaches DEPTH/2, and sets st_full when the new level reaches DEPTH.
- R7: A burst may start only when tx_en=1, slot3_en or slot4_en is 1, and the level is at least DEPTH/2. Pairs leave in write order, with the older sample on pair_left.
- R8: A burst that has started keeps offering pairs while the configuration allows it and at least two samples remain. It ends when fewer than two samples are left.
- R9: While pair_valid=1 and pair_ready=0, with the configuration enabled, pair_valid stays 1 and pair_left/pair_right stay unchanged.
- R10: A pop clears st_full. It sets st_half_empty when the new level is at most DEPTH/2, and sets st_empty and st_underrun when the new level is 0.
- R11: A push and a pop in the same cycle change the level by the samples pushed minus 2. The push flag rules are applied first and the pop flag rules after them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_en | input | 1 | Transmit enable |
| slot3_en | input | 1 | Left slot enable |
| slot4_en | input | 1 | Right slot enable |
| size_code | input | 2 | Sample width code |
| compact_req | input | 1 | Request two samples per word |
| in_valid | input | 1 | Data word offered |
| in_ready | output | 1 | Offered word would be accepted |
| in_data | input | WORD_W | Data word |
| pair_valid | output | 1 | Stereo pair offered to codec |
| pair_ready | input | 1 | Codec takes the pair |
| pair_left | output | 20 | Older sample of the pair |
| pair_right | output | 20 | Newer sample of the pair |
| st_empty | output | 1 | Empty flag |
| st_half_empty | output | 1 | Half-empty flag |
| st_full | output | 1 | Full flag |
| st_underrun | output | 1 | Underrun flag |

## Verification
A write push and a codec pop can land on the same clock edge, and both then change the level and the flags. The bench sets up a level of exactly DEPTH/2 with the codec stalled. It then raises `in_valid` and `pair_ready` together for one cycle.

It judges the result in two ways. First, the flags must match the push-then-pop order at a level of DEPTH/2-1: half-empty set and empty clear. Second, the burst must continue below the threshold and hand over the next pair, which shows the combined level change was right.

// File: rtl/atx_pkg.sv
package atx_pkg;
  localparam int SAMPLE_W = 20;
  typedef logic [SAMPLE_W-1:0] sample_t;

  typedef enum logic [1:0] {
    SZ16 = 2'd0,
    SZ18 = 2'd1,
    SZ20 = 2'd2,
    SZ12 = 2'd3
  } size_code_e;

  // normal-mode alignment shift per width code (R2)
  function automatic logic [3:0] norm_shift(input logic [1:0] code);
    case (size_code_e'(code))
      SZ16:    return 4'd4;
      SZ18:    return 4'd2;
      SZ20:    return 4'd0;
      default: return 4'd8;
    endcase
  endfunction

  // packed mode only exists for 12/16-bit widths (R4)
  function automatic logic pack_allowed(input logic [1:0] code);
    return (size_code_e'(code) == SZ16) || (size_code_e'(code) == SZ12);
  endfunction
endpackage

// File: rtl/atx_pack.sv
module atx_pack
  import atx_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic [WORD_W-1:0] word,
  input  logic [1:0]        code,
  input  logic              compact_req,
  output sample_t           samp0,
  output sample_t           samp1,
  output logic              two
);
  localparam int HALF_W = WORD_W / 2;

  logic [WORD_W-1:0] lo_ext, hi_ext, t_norm, t_lo, t_hi;
  logic [3:0]        pshift;

  always_comb begin
    two    = compact_req && pack_allowed(code);
    pshift = (size_code_e'(code) == SZ12) ? 4'd8 : 4'd4;
    lo_ext = {{(WORD_W-HALF_W){1'b0}}, word[HALF_W-1:0]};
    hi_ext = {{(WORD_W-HALF_W){1'b0}}, word[WORD_W-1:HALF_W]};
    t_norm = word << norm_shift(code);
    t_lo   = lo_ext << pshift;
    t_hi   = hi_ext << pshift;
    if (two) begin
      samp0 = t_lo[SAMPLE_W-1:0];
      samp1 = t_hi[SAMPLE_W-1:0];
    end else begin
      samp0 = t_norm[SAMPLE_W-1:0];
      samp1 = '0;
    end
  end
endmodule

// File: rtl/atx_ring.sv
module atx_ring
  import atx_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      push,
  input  logic                      two,
  input  sample_t                   d0,
  input  sample_t                   d1,
  input  logic                      pop,
  output sample_t                   rd0,
  output sample_t                   rd1,
  output logic [$clog2(DEPTH):0]    level,
  output logic [$clog2(DEPTH):0]    level_nx
);
  localparam int AW = $clog2(DEPTH);
  localparam int LW = AW + 1;

  sample_t        mem [DEPTH];
  logic [AW-1:0]  wr_ptr, rd_ptr, wr_ptr1, rd_ptr1;
  logic [LW-1:0]  n_in, n_out;

  assign wr_ptr1 = wr_ptr + AW'(1);
  assign rd_ptr1 = rd_ptr + AW'(1);
  assign rd0     = mem[rd_ptr];
  assign rd1     = mem[rd_ptr1];

  assign n_in     = push ? (two ? LW'(2) : LW'(1)) : LW'(0);
  assign n_out    = pop ? LW'(2) : LW'(0);
  assign level_nx = level + n_in - n_out;

  always_ff @(posedge clk) begin
    if (push) begin
      mem[wr_ptr] <= d0;
      if (two) mem[wr_ptr1] <= d1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      wr_ptr <= wr_ptr + n_in[AW-1:0];
      if (pop) rd_ptr <= rd_ptr + AW'(2);
      level  <= level_nx;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LW'(DEPTH)); // R5
  AST_POP_AVAIL: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> level >= LW'(2)); // R8
endmodule

// File: rtl/atx_status.sv
module atx_status #(
  parameter int DEPTH = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   push,
  input  logic                   pop,
  input  logic [$clog2(DEPTH):0] level_nx,
  output logic                   st_empty,
  output logic                   st_half_empty,
  output logic                   st_full,
  output logic                   st_underrun
);
  localparam int LW = $clog2(DEPTH) + 1;
  localparam logic [LW-1:0] HALF = LW'(DEPTH / 2);
  localparam logic [LW-1:0] FULL = LW'(DEPTH);

  // push rules first, pop rules last so they win (R11)
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_empty      <= 1'b1;
      st_half_empty <= 1'b1;
      st_full       <= 1'b0;
      st_underrun   <= 1'b0;
    end else begin
      if (push) begin
        if (level_nx != '0) begin
          st_empty    <= 1'b0;
          st_underrun <= 1'b0;
        end
        if (level_nx >= HALF) st_half_empty <= 1'b0;
        if (level_nx >= FULL) st_full       <= 1'b1;
      end
      if (pop) begin
        st_full <= 1'b0;
        if (level_nx <= HALF) st_half_empty <= 1'b1;
        if (level_nx == '0) begin
          st_empty    <= 1'b1;
          st_underrun <= 1'b1;
        end
      end
    end
  end

  AST_FULL_EMPTY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(st_full && st_empty)); // R6
endmodule

// File: rtl/audio_tx_fifo.sv
module audio_tx_fifo
  import atx_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_en,
  input  logic              slot3_en,
  input  logic              slot4_en,
  input  logic [1:0]        size_code,
  input  logic              compact_req,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_data,
  output logic              pair_valid,
  input  logic              pair_ready,
  output logic [19:0]       pair_left,
  output logic [19:0]       pair_right,
  output logic              st_empty,
  output logic              st_half_empty,
  output logic              st_full,
  output logic              st_underrun
);
  localparam int LW = $clog2(DEPTH) + 1;
  localparam logic [LW:0]   DEPTH_X = (LW+1)'(DEPTH);
  localparam logic [LW-1:0] HALF    = LW'(DEPTH / 2);

  sample_t       samp0, samp1;
  logic          two, push, pop, en_ok, burst;
  logic [LW-1:0] level, level_nx;

  atx_pack #(.WORD_W(WORD_W)) u_pack (
    .word(in_data), .code(size_code), .compact_req(compact_req),
    .samp0(samp0), .samp1(samp1), .two(two)
  );

  assign in_ready = two ? (({1'b0, level} + (LW+1)'(2)) < DEPTH_X)
                        : ({1'b0, level} < DEPTH_X);
  assign push  = in_valid && in_ready;
  assign en_ok = tx_en && (slot3_en || slot4_en);
  assign pair_valid = en_ok && ((level >= HALF) || (burst && level >= LW'(2)));
  assign pop   = pair_valid && pair_ready;

  atx_ring #(.DEPTH(DEPTH)) u_ring (
    .clk(clk), .rst_n(rst_n), .push(push), .two(two), .d0(samp0), .d1(samp1),
    .pop(pop), .rd0(pair_left), .rd1(pair_right), .level(level),
    .level_nx(level_nx)
  );

  atx_status #(.DEPTH(DEPTH)) u_status (
    .clk(clk), .rst_n(rst_n), .push(push), .pop(pop), .level_nx(level_nx),
    .st_empty(st_empty), .st_half_empty(st_half_empty), .st_full(st_full),
    .st_underrun(st_underrun)
  );

  // burst lives on after the threshold until fewer than two samples remain
  always_ff @(posedge clk) begin
    if (!rst_n)      burst <= 1'b0;
    else if (!en_ok) burst <= 1'b0;
    else if (pop)    burst <= (level_nx >= LW'(2));
  end

  AST_START_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pair_valid) |-> level >= HALF); // R7
  AST_PAIR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (pair_valid && !pair_ready && en_ok) |=>
      (!en_ok || (pair_valid && $stable(pair_left) && $stable(pair_right)))); // R9
endmodule

// File: tb/test_audio_tx_fifo.sv
`timescale 1ns/1ps
module test_audio_tx_fifo;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tx_en = 0, slot3_en = 0, slot4_en = 0, compact_req = 0;
  logic [1:0]  size_code = 0;
  logic        in_valid = 0, pair_ready = 0;
  logic [31:0] in_data = 0;
  logic        in_ready, pair_valid;
  logic [19:0] pair_left, pair_right;
  logic        st_empty, st_half_empty, st_full, st_underrun;

  int n_chk = 0, n_bad = 0, cap_n = 0;
  logic [19:0] cap_l [16];
  logic [19:0] cap_r [16];

  always #5 clk = ~clk;

  audio_tx_fifo #(.DEPTH(8), .WORD_W(32)) i_audio_tx_fifo (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .slot3_en(slot3_en),
    .slot4_en(slot4_en), .size_code(size_code), .compact_req(compact_req),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .pair_valid(pair_valid), .pair_ready(pair_ready), .pair_left(pair_left),
    .pair_right(pair_right), .st_empty(st_empty), .st_half_empty(st_half_empty),
    .st_full(st_full), .st_underrun(st_underrun)
  );

  // handshake is settled at the falling edge; it completes at the next rise
  always @(negedge clk)
    if (rst_n && pair_valid && pair_ready && cap_n < 16) begin
      cap_l[cap_n] = pair_left;
      cap_r[cap_n] = pair_right;
      cap_n = cap_n + 1;
    end

  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic chk(input logic [39:0] act, input logic [39:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_flags(input logic [3:0] exp, input string tag);
    chk({36'd0, st_empty, st_half_empty, st_full, st_underrun}, {36'd0, exp}, tag);
  endtask

  task automatic chk_pair(input int idx, input logic [19:0] l, input logic [19:0] r,
                          input string tag);
    chk({cap_l[idx], cap_r[idx]}, {l, r}, tag);
  endtask

  task automatic do_reset();
    rst_n = 0; tx_en = 0; slot3_en = 0; slot4_en = 0; compact_req = 0;
    size_code = 0; in_valid = 0; pair_ready = 0; in_data = 0;
    step(); step();
    rst_n = 1; cap_n = 0;
    step();
  endtask

  task automatic wr(input logic [31:0] d, input logic [1:0] code, input logic pk);
    in_data = d; size_code = code; compact_req = pk; in_valid = 1;
    step();
    in_valid = 0; compact_req = 0;
  endtask

  task automatic pulse_ready();
    pair_ready = 1; step(); pair_ready = 0;
  endtask

  task automatic t_reset();
    do_reset();
    chk_flags(4'b1100, "R1 reset flags");
    chk({39'd0, pair_valid}, 40'd0, "R1 reset pair_valid");
  endtask

  task automatic t_normal_sizes();
    do_reset();
    wr(32'h000ABCDE, 2'd2, 0);
    chk_flags(4'b0100, "R6 flags after first push");
    wr(32'h00012345, 2'd0, 0);
    wr(32'h0003FFFF, 2'd1, 0);
    chk_flags(4'b0100, "R6 half-empty held at level 3");
    wr(32'h00000FFF, 2'd3, 0);
    chk_flags(4'b0000, "R6 half-empty cleared at DEPTH/2");
    tx_en = 1; slot4_en = 1; pair_ready = 1;
    step(); step(); step();
    pair_ready = 0;
    chk(40'(cap_n), 40'd2, "R8 burst drains both pairs");
    chk_pair(0, 20'hABCDE, 20'h23450, "R2 codes 2/0 normal alignment");
    chk_pair(1, 20'hFFFFC, 20'hFFF00, "R2 codes 1/3 normal alignment");
    chk_flags(4'b1101, "R10 flags after draining to zero");
  endtask

  task automatic t_compact();
    do_reset();
    wr(32'hBBBBAAAA, 2'd0, 1);
    chk_flags(4'b0100, "R3 packed word gives level 2");
    wr(32'hF1230ABC, 2'd3, 1);
    chk_flags(4'b0000, "R3 two packed words reach DEPTH/2");
    tx_en = 1; slot3_en = 1; pair_ready = 1;
    step(); step(); step();
    pair_ready = 0;
    chk_pair(0, 20'hAAAA0, 20'hBBBB0, "R3 16-bit halves low first");
    chk_pair(1, 20'hABC00, 20'h12300, "R3 12-bit halves cut to 20 bits");
  endtask

  task automatic t_compact_forced_off();
    do_reset();
    wr(32'h00010003, 2'd1, 1);
    wr(32'h00020001, 2'd1, 1);
    chk_flags(4'b0100, "R4 packing ignored for 18-bit");
    wr(32'h000ABCDE, 2'd2, 1);
    wr(32'hFFF12345, 2'd2, 1);
    chk_flags(4'b0000, "R4 four words give level 4");
    tx_en = 1; slot3_en = 1; pair_ready = 1;
    step(); step(); step();
    pair_ready = 0;
    chk_pair(0, 20'h4000C, 20'h80004, "R4 18-bit single samples");
    chk_pair(1, 20'hABCDE, 20'h12345, "R4 20-bit single samples");
  endtask

  task automatic t_gate_and_hold();
    do_reset();
    tx_en = 1; slot3_en = 0; slot4_en = 0;
    wr(32'h1, 2'd2, 0); wr(32'h2, 2'd2, 0); wr(32'h3, 2'd2, 0); wr(32'h4, 2'd2, 0);
    chk({39'd0, pair_valid}, 40'd0, "R7 no slot enabled blocks drain");
    tx_en = 0; slot3_en = 1; #1;
    chk({39'd0, pair_valid}, 40'd0, "R7 tx disabled blocks drain");
    tx_en = 1; #1;
    chk({19'd0, pair_valid, pair_left}, {19'd0, 1'b1, 20'h00001}, "R7 drain offered at threshold");
    step(); step(); step();
    chk({pair_left, pair_right}, {20'h00001, 20'h00002}, "R9 pair held under back-pressure");
    chk({39'd0, pair_valid}, 40'd1, "R9 valid held under back-pressure");
    do_reset();
    tx_en = 1; slot3_en = 1;
    wr(32'h5, 2'd2, 0); wr(32'h6, 2'd2, 0); wr(32'h7, 2'd2, 0);
    chk({39'd0, pair_valid}, 40'd0, "R7 below threshold no drain");
  endtask

  task automatic t_overflow();
    do_reset();
    for (int i = 1; i <= 5; i++) wr(32'h10 + 32'(i), 2'd2, 0);
    size_code = 2'd0; compact_req = 1; #1;
    chk({39'd0, in_ready}, 40'd1, "R5 packed accepted at level 5");
    wr(32'h00070006, 2'd0, 1);
    chk_flags(4'b0000, "R5 level 7 not full");
    compact_req = 1; #1;
    chk({39'd0, in_ready}, 40'd0, "R5 packed refused at level 7");
    wr(32'h00090008, 2'd0, 1);
    size_code = 2'd2; #1;
    chk({39'd0, in_ready}, 40'd1, "R5 normal accepted at level 7");
    wr(32'h88, 2'd2, 0);
    chk_flags(4'b0010, "R6 full at DEPTH");
    chk({39'd0, in_ready}, 40'd0, "R5 normal refused when full");
    wr(32'h99, 2'd2, 0);
    tx_en = 1; slot3_en = 1;
    pulse_ready();
    chk_flags(4'b0000, "R10 full cleared, level 6");
    pulse_ready();
    chk_flags(4'b0100, "R10 half-empty set at level 4");
    pulse_ready(); pulse_ready();
    chk_flags(4'b1101, "R10 empty and underrun at zero");
    chk_pair(0, 20'h00011, 20'h00012, "R5 order pair 0");
    chk_pair(2, 20'h00015, 20'h00060, "R5 packed word kept");
    chk_pair(3, 20'h00070, 20'h00088, "R5 refused words absent");
  endtask

  task automatic t_same_cycle();
    do_reset();
    tx_en = 1; slot4_en = 1;
    wr(32'hA1, 2'd2, 0); wr(32'hA2, 2'd2, 0); wr(32'hA3, 2'd2, 0); wr(32'hA4, 2'd2, 0);
    in_data = 32'hA5; size_code = 2'd2; in_valid = 1; pair_ready = 1;
    step();
    in_valid = 0; pair_ready = 0;
    chk_flags(4'b0100, "R11 push+pop flags at level 3");
    chk({39'd0, pair_valid}, 40'd1, "R8 burst continues below threshold");
    pulse_ready();
    chk_pair(0, 20'h000A1, 20'h000A2, "R11 first pair");
    chk_pair(1, 20'h000A3, 20'h000A4, "R11 second pair");
    chk({39'd0, pair_valid}, 40'd0, "R8 burst ends at level 1");
    wr(32'hA6, 2'd2, 0);
    chk({39'd0, pair_valid}, 40'd0, "R8 no restart below threshold");
    wr(32'hA7, 2'd2, 0); wr(32'hA8, 2'd2, 0); #1;
    chk({pair_left, pair_right}, {20'h000A5, 20'h000A6}, "R11 pushed sample kept in order");
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_normal_sizes();
    t_compact();
    t_compact_forced_off();
    t_gate_and_hold();
    t_overflow();
    t_same_cycle();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule